// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block lets a host reach the management registers of an Ethernet PHY. The host sees two registers. A command register holds a PHY address, a register number and a direction bit, and it shows a busy flag. A data register holds the 16-bit value that is sent or received. The block turns each command into a serial management frame on a divided clock (MDC) and a bidirectional data line (MDIO). The data line appears as separate output, output-enable and input pins, so that the pad can sit outside the block.

For a write, the host loads the data register first and then writes the command register. That command write starts the whole frame. For a read, the host writes the command register and waits until busy clears, after which the data register holds the value returned by the PHY. While busy is set, the block ignores every host write, so a running frame can never be corrupted or restarted.

The MDC half period is fixed when the block is elaborated. It is derived from the system clock period and a minimum MDC period, which defaults to 400 ns. With a 20 ns system clock, each half of MDC is 10 clocks long.

Top module: `mdioMgmt`

## Requirements
- R1: After reset, the command readback and the data readback are both zero, MDC is low and MDIO is not driven (output enable low).
- R2: Command register layout: bits 4:0 hold the register number, bits 9:5 the PHY address, bit 10 the direction (1 = read, 0 = write), and bit 15 the busy flag. Bits 14:11 read as zero. The readback shows the fields of the last accepted command.
- R3: A data register write while idle loads the value, and the data readback returns it on the next cycle.
- R4: A command register write while idle starts a frame. Busy reads as 1 from the cycle after that write and stays set for exactly 128 × MDC half-period clock cycles.
- R5: MDC stays low while idle. During a frame its period is 2 × the half period (400 ns at the defaults) and is never shorter than the minimum MDC period.
- R6: A frame is 64 bits, sent MSB first, with each bit driven before its MDC rising edge. The bits are: 32 ones, start 01, opcode 10 for a read or 01 for a write, the 5-bit PHY address, the 5-bit register number, then for a write the turnaround 10 and the 16 data bits. MDIO changes only while MDC is low.
- R7: In a read frame, the controller drives only the first 46 bits. It releases MDIO (output enable low) for the two turnaround bits and the 16 data bits, and it samples MDIO on each MDC rising edge of the data bits.
- R8: When busy clears after a read, the data readback holds the 16 bits sampled from the PHY, MSB first.
- R9: A command register write while busy is ignored. The fields do not change, and no second frame follows.
- R10: A data register write while busy is ignored. It changes neither the frame in progress nor the final content of the data register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Host register write strobe |
| regSel | input | 1 | Register select: 0 = command, 1 = data |
| regWrData | input | 16 | Host write value |
| ctrlRd | output | 16 | Command register readback, including the busy flag |
| dataRd | output | 16 | Data register readback |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | MDIO value when driven |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO value seen at the pad |

## Verification
The bench drives every input on the falling system-clock edge and samples every output on the next falling edge. A register write is therefore visible in the readback at the first sample after it, and busy is expected high at that same sample. From there the bench counts the samples for which busy stays high and expects exactly 1280 at the default divider. At that point the read result must already be in the data register. Frame bits, output-enable state and MDC period are captured on each MDC rising edge while the frame runs. Once 64 edges have been seen, the bits are compared against the frame that the driver queued. Writes made in the middle of a frame are judged only after busy clears, through the readbacks and the captured frame.

// File: rtl/mdioPkg.sv
`timescale 1ns/1ps
package mdioPkg;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_DATA = 1'b1
  } regSelT;

  // Strobes and phase flags from the sequencer to the datapath
  typedef struct packed {
    logic busy;      // frame in progress
    logic launch;    // accepted command write
    logic dataWr;    // accepted data write
    logic rise;      // MDC rises this cycle
    logic fall;      // MDC falls this cycle
    logic finish;    // last falling edge of the frame
    logic pastAddr;  // bit index reached the turnaround
    logic inData;    // bit index reached the data bits
  } mdioStrobeT;

endpackage

// File: rtl/mdioSeqCtrl.sv
`timescale 1ns/1ps
module mdioSeqCtrl
  import mdioPkg::*;
#(
  parameter int FRAME_BITS = 64,
  parameter int TA_POS     = 46,
  parameter int DATA_POS   = 48,
  parameter int MDC_HALF   = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic       regSel,
  output mdioStrobeT st,
  output logic       mdc
);

  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam int DIV_W = $clog2(MDC_HALF + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(DATA_POS);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(MDC_HALF - 1);

  logic             busyQ;
  logic             mdcQ;
  logic [DIV_W-1:0] divCnt;
  logic [IDX_W-1:0] bitIdx;
  logic             halfDone;
  logic             launch;

  assign halfDone = busyQ && (divCnt == DIV_LAST);
  assign launch   = regWrEn && (regSel == SEL_CTRL) && !busyQ;

  always_comb begin
    st.busy     = busyQ;
    st.launch   = launch;
    st.dataWr   = regWrEn && (regSel == SEL_DATA) && !busyQ;
    st.rise     = halfDone && !mdcQ;
    st.fall     = halfDone && mdcQ;
    st.finish   = halfDone && mdcQ && (bitIdx == LAST_IDX);
    st.pastAddr = bitIdx >= TA_IDX;
    st.inData   = bitIdx >= DATA_IDX;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      mdcQ   <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
    end else if (launch) begin
      busyQ  <= 1'b1;
      mdcQ   <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
    end else if (busyQ) begin
      if (halfDone) begin
        divCnt <= '0;
        mdcQ   <= ~mdcQ;
        if (mdcQ) begin
          if (bitIdx == LAST_IDX) begin
            busyQ <= 1'b0;
          end else begin
            bitIdx <= bitIdx + 1'b1;
          end
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign mdc = mdcQ;

  AST_LAUNCH_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> $past(regWrEn && (regSel == SEL_CTRL))); // R4

  AST_FRAME_STARTS_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> (bitIdx == '0) && (divCnt == '0) && !mdcQ); // R4

  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !busyQ |-> !mdcQ); // R5

  AST_NO_RELAUNCH: assert property (@(posedge clk) disable iff (!rstN)
    busyQ && !halfDone |=> busyQ); // R9

endmodule

// File: rtl/mdioDatapath.sv
`timescale 1ns/1ps
module mdioDatapath
  import mdioPkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 16,
  parameter int PRE_BITS   = 32,
  parameter int FRAME_BITS = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  mdioStrobeT        st,
  input  logic              mdcIn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              mdioIn,
  output logic [DATA_W-1:0] ctrlRd,
  output logic [DATA_W-1:0] dataRd,
  output logic              mdioOut,
  output logic              mdioOe
);

  localparam int DIR_BIT  = 2 * ADDR_W;
  localparam int BUSY_BIT = DATA_W - 1;

  logic [ADDR_W-1:0]     phyQ;
  logic [ADDR_W-1:0]     regQ;
  logic                  dirQ;
  logic [DATA_W-1:0]     dataQ;
  logic [DATA_W-1:0]     capQ;
  logic [FRAME_BITS-1:0] shiftQ;
  logic [FRAME_BITS-1:0] frameNext;
  logic [ADDR_W-1:0]     wrPhy;
  logic [ADDR_W-1:0]     wrReg;
  logic                  wrDir;
  logic [1:0]            opCode;

  assign wrReg  = regWrData[ADDR_W-1:0];
  assign wrPhy  = regWrData[2*ADDR_W-1:ADDR_W];
  assign wrDir  = regWrData[DIR_BIT];
  assign opCode = wrDir ? 2'b10 : 2'b01;

  assign frameNext = {{PRE_BITS{1'b1}}, 2'b01, opCode, wrPhy, wrReg, 2'b10, dataQ};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phyQ   <= '0;
      regQ   <= '0;
      dirQ   <= 1'b0;
      shiftQ <= '0;
    end else if (st.launch) begin
      phyQ   <= wrPhy;
      regQ   <= wrReg;
      dirQ   <= wrDir;
      shiftQ <= frameNext;
    end else if (st.fall) begin
      shiftQ <= {shiftQ[FRAME_BITS-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capQ <= '0;
    end else if (st.rise && st.inData && dirQ) begin
      capQ <= {capQ[DATA_W-2:0], mdioIn};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataQ <= '0;
    end else if (st.dataWr) begin
      dataQ <= regWrData;
    end else if (st.finish && dirQ) begin
      dataQ <= capQ;
    end
  end

  always_comb begin
    ctrlRd                  = '0;
    ctrlRd[ADDR_W-1:0]      = regQ;
    ctrlRd[DIR_BIT-1:ADDR_W] = phyQ;
    ctrlRd[DIR_BIT]         = dirQ;
    ctrlRd[BUSY_BIT]        = st.busy;
  end

  assign dataRd  = dataQ;
  assign mdioOut = shiftQ[FRAME_BITS-1];
  assign mdioOe  = st.busy && !(dirQ && st.pastAddr);

  AST_MDIO_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (mdcIn && $past(mdcIn)) |-> $stable(mdioOut)); // R6

  AST_DRIVE_ONLY_AFTER_LAUNCH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdioOe) |-> $past(st.launch)); // R7

  AST_CTRL_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    st.busy |=> $stable({phyQ, regQ, dirQ})); // R9

  AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (st.busy && !st.finish) |=> $stable(dataQ)); // R10

endmodule

// File: rtl/mdioMgmt.sv
`timescale 1ns/1ps
module mdioMgmt
  import mdioPkg::*;
#(
  parameter int CLK_NS     = 20,
  parameter int MDC_MIN_NS = 400,
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 16,
  parameter int PRE_BITS   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] ctrlRd,
  output logic [DATA_W-1:0] dataRd,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);

  localparam int HALF_RAW   = (MDC_MIN_NS + 2 * CLK_NS - 1) / (2 * CLK_NS);
  localparam int MDC_HALF   = (HALF_RAW < 1) ? 1 : HALF_RAW;
  localparam int TA_POS     = PRE_BITS + 4 + 2 * ADDR_W;
  localparam int DATA_POS   = TA_POS + 2;
  localparam int FRAME_BITS = DATA_POS + DATA_W;

  mdioStrobeT st;

  mdioSeqCtrl #(
    .FRAME_BITS(FRAME_BITS),
    .TA_POS    (TA_POS),
    .DATA_POS  (DATA_POS),
    .MDC_HALF  (MDC_HALF)
  ) i_seq (
    .clk    (clk),
    .rstN   (rstN),
    .regWrEn(regWrEn),
    .regSel (regSel),
    .st     (st),
    .mdc    (mdc)
  );

  mdioDatapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PRE_BITS  (PRE_BITS),
    .FRAME_BITS(FRAME_BITS)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .mdcIn    (mdc),
    .regWrData(regWrData),
    .mdioIn   (mdioIn),
    .ctrlRd   (ctrlRd),
    .dataRd   (dataRd),
    .mdioOut  (mdioOut),
    .mdioOe   (mdioOe)
  );

endmodule

// File: tb/test_mdioMgmt.sv
`timescale 1ns/1ps
module test_mdioMgmt;

  localparam int CLK_NS     = 20;
  localparam int HALF       = 10;
  localparam int BUSY_CYC   = 128 * HALF;
  localparam int MDC_NS     = 2 * HALF * CLK_NS;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regSel = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] ctrlRd;
  logic [15:0] dataRd;
  logic        mdc;
  logic        mdioOut;
  logic        mdioOe;
  logic        mdioIn = 1'b1;

  int nChecks = 0;
  int nFail = 0;
  bit doneFlag = 1'b0;

  logic [63:0] expFrameQ[$];
  logic [63:0] expMaskQ[$];
  logic        curRead = 1'b0;
  logic [15:0] phyReturn = '0;

  int          riseCnt = 0;
  logic [63:0] capF = '0;
  logic [63:0] capO = '0;
  realtime     lastRise = 0;
  bit          periodBad = 1'b0;

  always #(CLK_NS / 2) clk = ~clk;

  mdioMgmt i_mdioMgmt (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regSel   (regSel),
    .regWrData(regWrData),
    .ctrlRd   (ctrlRd),
    .dataRd   (dataRd),
    .mdc      (mdc),
    .mdioOut  (mdioOut),
    .mdioOe   (mdioOe),
    .mdioIn   (mdioIn)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: capture every MDC rising edge, compare a complete frame against the queue
  always @(posedge mdc) begin
    if (riseCnt > 0 && ($realtime - lastRise) != MDC_NS) periodBad = 1'b1;
    lastRise = $realtime;
    capF = {capF[62:0], mdioOut};
    capO = {capO[62:0], mdioOe};
    riseCnt++;
    if (riseCnt == 64) begin
      logic [63:0] ef, em;
      check(!periodBad, "R5 mdc period", {63'd0, periodBad}, 64'd0);
      periodBad = 1'b0;
      if (expFrameQ.size() == 0) begin
        check(1'b0, "R6 unexpected frame", capF, 64'd0);
      end else begin
        ef = expFrameQ.pop_front();
        em = expMaskQ.pop_front();
        check((capF & em) == (ef & em), "R6 frame bits", capF & em, ef & em);
        check(capO == em, "R7 drive window", capO, em);
      end
      riseCnt = 0;
    end
  end

  // PHY model: drive turnaround zero and read data on MDC falling edges
  always @(negedge mdc) begin
    if (curRead && riseCnt == 47) mdioIn = 1'b0;
    else if (curRead && riseCnt >= 48 && riseCnt <= 63) mdioIn = phyReturn[63 - riseCnt];
    else mdioIn = 1'b1;
  end

  task automatic hostWrite(input logic sel, input logic [15:0] val);
    @(negedge clk);
    regWrEn = 1'b1;
    regSel = sel;
    regWrData = val;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic runTxn(input logic rd, input logic [4:0] phy, input logic [4:0] rg,
                        input logic [15:0] wdata, input logic [15:0] phyData,
                        input bit injCtrl, input bit injData);
    logic [15:0] cmd, badCmd;
    logic [63:0] ef, em;
    int cnt;
    cmd = {5'd0, rd, phy, rg};
    badCmd = {5'd0, ~rd, ~phy, ~rg};
    if (!rd) begin
      hostWrite(1'b1, wdata);
      check(dataRd == wdata, "R3 data load", {48'd0, dataRd}, {48'd0, wdata});
    end
    ef = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, wdata};
    em = rd ? ~64'h3FFFF : {64{1'b1}};
    expFrameQ.push_back(ef);
    expMaskQ.push_back(em);
    curRead = rd;
    phyReturn = phyData;
    hostWrite(1'b0, cmd);
    check(ctrlRd[15] == 1'b1, "R4 busy set", {63'd0, ctrlRd[15]}, 64'd1);
    check(ctrlRd[14:0] == cmd[14:0], "R2 command fields", {49'd0, ctrlRd[14:0]}, {49'd0, cmd[14:0]});
    cnt = 0;
    while (ctrlRd[15]) begin
      cnt++;
      if (cnt == 100 && injCtrl) begin
        regWrEn = 1'b1; regSel = 1'b0; regWrData = badCmd;
      end else if (cnt == 200 && injData) begin
        regWrEn = 1'b1; regSel = 1'b1; regWrData = 16'hDEAD;
      end else begin
        regWrEn = 1'b0;
      end
      @(negedge clk);
      if (cnt > BUSY_CYC + 50) break;
    end
    regWrEn = 1'b0;
    check(cnt == BUSY_CYC, "R4 busy length", cnt, BUSY_CYC);
    check(ctrlRd == cmd, injCtrl ? "R9 command kept" : "R2 readback", {48'd0, ctrlRd}, {48'd0, cmd});
    if (rd) begin
      check(dataRd == phyData, injData ? "R10 read result kept" : "R8 read result",
            {48'd0, dataRd}, {48'd0, phyData});
    end else if (injData) begin
      check(dataRd == wdata, "R10 data kept", {48'd0, dataRd}, {48'd0, wdata});
    end
    repeat (30) @(negedge clk);
    check(ctrlRd[15] == 1'b0 && mdc == 1'b0 && mdioOe == 1'b0, "R9 R5 idle after frame",
          {61'd0, ctrlRd[15], mdc, mdioOe}, 64'd0);
    check(expFrameQ.size() == 0, "R6 frame seen", expFrameQ.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(ctrlRd == 16'd0, "R1 ctrl reset", {48'd0, ctrlRd}, 64'd0);
    check(dataRd == 16'd0, "R1 data reset", {48'd0, dataRd}, 64'd0);
    check(mdc == 1'b0 && mdioOe == 1'b0, "R1 bus idle", {62'd0, mdc, mdioOe}, 64'd0);
    repeat (5) @(negedge clk);
    check(mdc == 1'b0, "R5 mdc idle low", {63'd0, mdc}, 64'd0);

    runTxn(1'b0, 5'd1,  5'd0,  16'hA5C3, 16'h0000, 1'b0, 1'b0);
    runTxn(1'b0, 5'd31, 5'd31, 16'hFFFF, 16'h0000, 1'b1, 1'b1);
    runTxn(1'b1, 5'd5,  5'd2,  16'h0000, 16'h1234, 1'b0, 1'b0);
    runTxn(1'b1, 5'd17, 5'd9,  16'h0000, 16'h8001, 1'b1, 1'b1);
    runTxn(1'b0, 5'd0,  5'd0,  16'h0000, 16'h0000, 1'b0, 1'b0);

    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    #(200000 * CLK_NS);
    if (!doneFlag) begin
      doneFlag = 1'b1;
      check(1'b0, "watchdog expired", 64'd0, 64'd1);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

endmodule